// File: doc/BRIEF.md
# PWM Event Blanking Window Filter

This block sits between the digital-compare event sources of a PWM channel and the logic that acts on them. One of four candidate event inputs is selected. It is then passed to a single filtered output, except while a blanking window is open. While the window is open, every occurrence of the selected event is suppressed. This hides switching noise on comparator-derived events just after a PWM edge.

The window is tied to the PWM time base. An alignment pulse arms a two-stage countdown. The pulse can be the counter-at-period strobe, the counter-at-zero strobe, or either of them. First, an offset of a programmed number of time-base ticks runs down. Then the window opens and stays open for a programmed number of ticks. Every qualifying alignment pulse restarts the sequence, even if a window is still open, so each window starts at the same distance from its pulse. Both counters advance only on ticks, which are clock cycles with the time-base enable high. A status output shows when the window is open.

Top module: `pwm_blank_filter`

## Requirements
- R1: `src_sel` picks the filtered source: 0 selects `evt_in[0]` (A1), 1 selects `evt_in[1]` (A2), 2 selects `evt_in[2]` (B1), and 3 selects `evt_in[3]` (B2).
- R2: When `blank_en` is 0, `evt_out` equals the selected source, `blank_active` stays 0, and alignment pulses start nothing.
- R3: `align_sel` picks the alignment pulse: 0 is `ctr_prd` only, 1 is `ctr_zero` only, and 2 or 3 is either of them. A pulse counts only in a cycle where `tb_tick` is 1, and a pulse that is not selected starts nothing.
- R4: Let the alignment pulse be taken at tick k, with offset N and length W greater than 0. `blank_active` is then 1 for exactly the cycles after ticks k+N through k+N+W-1, counted in ticks after k.
- R5: With an offset of 0, the window opens in the cycle that follows the alignment tick.
- R6: With a window length of 0, an alignment pulse produces no blanking.
- R7: An alignment pulse that arrives while the offset or the window is running restarts the offset countdown from that pulse.
- R8: Both countdowns hold their value in cycles where `tb_tick` is 0, so the window is measured in ticks and not in clock cycles.
- R9: While `blank_active` is 1 and blanking is enabled, `evt_out` is 0. In all other cycles, `evt_out` equals the selected source in the same cycle.
- R10: Synchronous active-high `rst` closes the window and clears both countdowns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_tick | input | 1 | Time-base clock enable; one tick per high cycle |
| ctr_prd | input | 1 | Counter-equals-period strobe |
| ctr_zero | input | 1 | Counter-equals-zero strobe |
| evt_in | input | 4 | Candidate events: A1, A2, B1, B2 at bits 0..3 |
| blank_en | input | 1 | Enables blanking |
| src_sel | input | 2 | Source select |
| align_sel | input | 2 | Alignment pulse select |
| offset_cnt | input | CNT_W | Offset in ticks before the window opens |
| window_cnt | input | CNT_W | Window length in ticks |
| evt_out | output | 1 | Filtered event |
| blank_active | output | 1 | Window open status |

## Verification
The hardest case to reach is a restart in the middle of a window. A second alignment pulse has to land while the window is already open, and the close that is then expected must be counted from the new pulse. The bench reaches this by issuing a second strobe a few cycles into a running window. It then checks every cycle against a tick counter that it resets at that strobe. Tick gating is covered in the same way: `tb_tick` is dropped in a fixed pattern, and the bench counts only the enabled cycles.

// File: rtl/pwmblank_pkg.sv
package pwmblank_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_OFFSET = 2'd1,
        PH_WINDOW = 2'd2
    } blank_phase_e;

    typedef enum logic [1:0] {
        ALN_PRD   = 2'd0,
        ALN_ZERO  = 2'd1,
        ALN_BOTH  = 2'd2,
        ALN_BOTH2 = 2'd3
    } align_mode_e;

    typedef struct packed {
        logic prd;
        logic zero;
    } tb_strobe_t;

    function automatic logic strobe_selected(align_mode_e mode, tb_strobe_t s);
        unique case (mode)
            ALN_PRD:  return s.prd;
            ALN_ZERO: return s.zero;
            default:  return s.prd | s.zero;
        endcase
    endfunction

endpackage

// File: rtl/blank_src_mux.sv
module blank_src_mux #(
    parameter int N_SRC = 4,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] evt_in,
    input  logic [SEL_W-1:0] sel,
    output logic             evt_sel
);
    always_comb begin
        evt_sel = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) evt_sel = evt_in[i];
        end
    end
endmodule

// File: rtl/blank_align.sv
module blank_align
    import pwmblank_pkg::*;
(
    input  logic        tick,
    input  tb_strobe_t  strobe,
    input  logic [1:0]  mode,
    output logic        align_hit
);
    always_comb begin
        align_hit = tick & strobe_selected(align_mode_e'(mode), strobe);
    end
endmodule

// File: rtl/blank_timer.sv
module blank_timer
    import pwmblank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic             align_hit,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] window,
    output logic             active
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    blank_phase_e     phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (align_hit) begin
            if (window == '0) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else if (offset == '0) begin
                phase <= PH_WINDOW;
                cnt   <= window;
            end else begin
                phase <= PH_OFFSET;
                cnt   <= offset;
            end
        end else if (tick) begin
            unique case (phase)
                PH_OFFSET: begin
                    if (cnt == ONE) begin
                        phase <= (window == '0) ? PH_IDLE : PH_WINDOW;
                        cnt   <= window;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_WINDOW: begin
                    if (cnt == ONE) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign active = (phase == PH_WINDOW);

    assert_zero_offset_opens_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && align_hit && offset == '0 && window != '0) |=> active);

    assert_zero_window_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (enable && align_hit && window == '0) |=> !active);

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> ($stable(cnt) && $stable(phase)));

    assert_restart_offset_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && align_hit && offset != '0 && window != '0) |=> (phase == PH_OFFSET && cnt == $past(offset)));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!active && cnt == '0));
endmodule

// File: rtl/pwm_blank_filter.sv
module pwm_blank_filter
    import pwmblank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_tick,
    input  logic             ctr_prd,
    input  logic             ctr_zero,
    input  logic [3:0]       evt_in,
    input  logic             blank_en,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       align_sel,
    input  logic [CNT_W-1:0] offset_cnt,
    input  logic [CNT_W-1:0] window_cnt,
    output logic             evt_out,
    output logic             blank_active
);
    localparam int N_SRC = 4;

    logic       evt_sel;
    logic       align_hit;
    tb_strobe_t strobe;

    assign strobe = '{prd: ctr_prd, zero: ctr_zero};

    blank_src_mux #(.N_SRC(N_SRC)) u_mux (
        .evt_in  (evt_in),
        .sel     (src_sel),
        .evt_sel (evt_sel)
    );

    blank_align u_align (
        .tick      (tb_tick),
        .strobe    (strobe),
        .mode      (align_sel),
        .align_hit (align_hit)
    );

    blank_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tb_tick),
        .enable    (blank_en),
        .align_hit (align_hit),
        .offset    (offset_cnt),
        .window    (window_cnt),
        .active    (blank_active)
    );

    assign evt_out = evt_sel & ~(blank_en & blank_active);

    assert_out_from_source_R1: assert property (@(posedge clk) disable iff (rst)
        evt_out |-> evt_in[src_sel]);

    assert_blank_suppresses_R9: assert property (@(posedge clk) disable iff (rst)
        blank_active |-> !evt_out);

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !blank_en |=> !blank_active);
endmodule

// File: tb/sim_pwm_blank_filter.sv
module sim_pwm_blank_filter;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             tb_tick;
    logic             ctr_prd;
    logic             ctr_zero;
    logic [3:0]       evt_in;
    logic             blank_en;
    logic [1:0]       src_sel;
    logic [1:0]       align_sel;
    logic [CNT_W-1:0] offset_cnt;
    logic [CNT_W-1:0] window_cnt;
    logic             evt_out;
    logic             blank_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    pwm_blank_filter #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tb_tick(tb_tick), .ctr_prd(ctr_prd), .ctr_zero(ctr_zero),
        .evt_in(evt_in), .blank_en(blank_en), .src_sel(src_sel), .align_sel(align_sel),
        .offset_cnt(offset_cnt), .window_cnt(window_cnt),
        .evt_out(evt_out), .blank_active(blank_active)
    );

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic test_reset();
        rst = 1; tb_tick = 1; ctr_prd = 0; ctr_zero = 0; evt_in = 4'b0001;
        blank_en = 1; src_sel = 0; align_sel = 0; offset_cnt = 0; window_cnt = 0;
        next_cycle(); next_cycle();
        rst = 0;
        #2;
        check("R10 reset active", blank_active, 0);
        check("R1 reset passthrough", evt_out, 1);
        next_cycle();
    endtask

    task automatic test_src_select();
        for (int en = 0; en < 2; en++) begin
            blank_en = en[0];
            for (int s = 0; s < 4; s++) begin
                src_sel = s[1:0];
                for (int p = 0; p < 3; p++) begin
                    logic [3:0] pat;
                    pat = (p == 0) ? (4'b0001 << s) : ((p == 1) ? ~(4'b0001 << s) : 4'b1010);
                    evt_in = pat;
                    #2;
                    check(en ? "R1 source select" : "R2 disabled passthrough", evt_out, pat[s]);
                    next_cycle();
                end
            end
        end
    endtask

    // Drives one alignment strobe, then checks each cycle against a tick count.
    task automatic run_window(string req, int n, int w, int al, bit use_zero, bit en,
                              int restart_at, bit gaps);
        int  t;
        bit  armed;
        int  len;
        bit  exp_act;
        bit  tk;
        blank_en = en; offset_cnt = CNT_W'(n); window_cnt = CNT_W'(w);
        align_sel = al[1:0]; src_sel = 2; evt_in = 4'b0100;
        tb_tick = 1; ctr_prd = !use_zero; ctr_zero = use_zero;
        armed = (al == 0) ? !use_zero : ((al == 1) ? use_zero : 1'b1);
        next_cycle();
        ctr_prd = 0; ctr_zero = 0;
        t = 0;
        len = (gaps ? 2 : 1) * (n + w + restart_at) + 4;
        for (int j = 1; j <= len; j++) begin
            bit rs;
            rs = (restart_at != 0) && (j == restart_at);
            tk = gaps ? ((j % 3) != 0 || rs) : 1'b1;
            tb_tick = tk;
            ctr_prd = rs && !use_zero;
            ctr_zero = rs && use_zero;
            exp_act = en && armed && (w != 0) && (t >= n) && (t <= n + w - 1);
            #2;
            check({req, " active"}, blank_active, exp_act);
            check({req, " evt_out"}, evt_out, !exp_act);
            next_cycle();
            if (rs) t = 0;
            else if (tk) t++;
        end
        ctr_prd = 0; ctr_zero = 0; tb_tick = 1;
    endtask

    task automatic test_reset_midwindow();
        blank_en = 1; offset_cnt = 0; window_cnt = 6; align_sel = 1;
        src_sel = 3; evt_in = 4'b1000; tb_tick = 1; ctr_zero = 1;
        next_cycle();
        ctr_zero = 0;
        #2;
        check("R5 window open", blank_active, 1);
        rst = 1;
        next_cycle();
        rst = 0;
        #2;
        check("R10 reset closes window", blank_active, 0);
        check("R10 reset passthrough", evt_out, 1);
        next_cycle();
        #2;
        check("R10 stays closed", blank_active, 0);
        next_cycle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_src_select();
        run_window("R4 basic",        3, 4, 0, 0, 1, 0, 0);
        run_window("R5 zero offset",  0, 2, 1, 1, 1, 0, 0);
        run_window("R6 zero window",  2, 0, 0, 0, 1, 0, 0);
        run_window("R3 unselected",   1, 3, 1, 0, 1, 0, 0);
        run_window("R3 either zero",  1, 2, 2, 1, 1, 0, 0);
        run_window("R3 either prd",   2, 2, 3, 0, 1, 0, 0);
        run_window("R7 restart",      2, 6, 0, 0, 1, 5, 0);
        run_window("R7 restart off",  4, 3, 1, 1, 1, 2, 0);
        run_window("R8 tick gaps",    2, 3, 0, 0, 1, 0, 1);
        run_window("R2 disabled",     1, 3, 0, 0, 0, 0, 0);
        run_window("R9 long window",  1, 9, 2, 0, 1, 0, 0);
        test_reset_midwindow();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule